// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast clock by a programmable whole-number ratio built from two cooperating counters that steer a dual-modulus prescaler. A main count N and a swallow count A are loaded together at the start of each output cycle. While the swallow count is still non-zero, the prescaler divides by M+1. Once it has run out, the prescaler divides by M until the main count expires. One output cycle therefore lasts (M × N) + A fast clocks. M is 64 or 128, chosen by a single select bit.

The block sits in the feedback path of a frequency synthesizer. The divided pulse goes to a phase comparator outside the block. The modulus-control signal is brought out so that it can be observed. Settings arrive on plain parallel inputs and are checked every clock. A legal setting is held in a pending register and is applied only at the next output-cycle boundary. An illegal setting raises an error flag and is dropped, so the last legal setting stays in force.

Top module: `pswallow_fbdiv`

## Requirements
- R1: The time from one `div_pulse` to the next, in fast clocks, equals M × N + A. M is 64 when `msel_in` = 0 and 128 when `msel_in` = 1.
- R2: `div_pulse` is high for exactly one fast clock in each output cycle.
- R3: In each output cycle, `mod_ctrl` is high for exactly A × (M+1) fast clocks, and those clocks come first. `mod_ctrl` rises only in a clock where `div_pulse` is high. When A = 0, `mod_ctrl` stays low.
- R4: A setting presented during an output cycle does not change that cycle's length. It applies from the next cycle boundary.
- R5: If `n_in` < 3, `cfg_err` is high on the following clock and the setting is ignored.
- R6: If `a_in` ≥ `n_in`, `cfg_err` is high on the following clock and the setting is ignored.
- R7: When a legal setting is presented, `cfg_err` is low on the following clock.
- R8: A synchronous active-high reset drives all outputs low and restores the default setting N = 3, A = 0, M = 64, which gives a ratio of 192.
- R9: The extreme legal settings N = 2047 with A = 127, and N = 3 with A = 2, give ratios of 131135 and 194 when M = 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| n_in | input | 11 | Main count N (legal range 3 to 2047) |
| a_in | input | 7 | Swallow count A (legal range 0 to 127, and below N) |
| msel_in | input | 1 | Modulus select: 0 gives 64/65, 1 gives 128/129 |
| div_pulse | output | 1 | One-clock pulse at each output-cycle boundary |
| mod_ctrl | output | 1 | High while the prescaler divides by M+1 |
| cfg_err | output | 1 | High after an illegal setting was presented |

## Verification
The bench checks the smallest legal case, N = 3 with A = N−1. If the counters reloaded one step late here, or the last prescaler period were counted at M+1, the period would miss 194 by a few clocks. A setting is changed a hundred clocks into a cycle; a design that loaded early would produce one cycle whose length falls between the old and new ratios. Rejected settings (N below 3, A equal to N, A above N) are followed by full cycles at the previous ratio, which exposes a design that keeps part of a bad setting. The largest N with the largest A exposes truncation in the count width or in the swallow phase.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  localparam int PS_N_W = 11;
  localparam int PS_A_W = 7;

  typedef struct packed {
    logic              msel;
    logic [PS_N_W-1:0] n;
    logic [PS_A_W-1:0] a;
  } ps_cfg_t;

  // Legal when N is at least the minimum and A is strictly below N.
  function automatic logic ps_cfg_legal(input ps_cfg_t c, input int n_min);
    logic [PS_N_W-1:0] a_ext;
    a_ext = {{(PS_N_W-PS_A_W){1'b0}}, c.a};
    return (int'(c.n) >= n_min) && (a_ext < c.n);
  endfunction

endpackage

// File: rtl/ps_cfg_guard.sv
module ps_cfg_guard
  import pswallow_pkg::*;
#(
  parameter int N_MIN    = 3,
  parameter int RST_N    = 3,
  parameter int RST_A    = 0,
  parameter int RST_MSEL = 0
) (
  input  logic    clk,
  input  logic    rst,
  input  ps_cfg_t req,
  output ps_cfg_t pend,
  output logic    cfg_err
);

  localparam ps_cfg_t CFG_RST = '{msel: RST_MSEL[0],
                                  n:    PS_N_W'(RST_N),
                                  a:    PS_A_W'(RST_A)};

  logic req_ok;

  always_comb req_ok = ps_cfg_legal(req, N_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= CFG_RST;
      cfg_err <= 1'b0;
    end else if (req_ok) begin
      pend    <= req;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/ps_dual_mod_prescaler.sv
module ps_dual_mod_prescaler #(
  parameter int M_LO     = 64,
  parameter int RST_MSEL = 0,
  parameter int RST_PLUS = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic ld_msel,
  input  logic ld_plus,
  output logic tc
);

  localparam int M_HI = 2 * M_LO;
  localparam int PC_W = $clog2(M_HI + 1);
  localparam logic [PC_W-1:0] PC_RST =
    PC_W'((RST_MSEL != 0 ? M_HI : M_LO) - 1 + RST_PLUS);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] reload;

  // Terminal count of the current prescaler period.
  assign tc = (pc == '0);

  always_comb begin
    reload = ld_msel ? PC_W'(M_HI - 1) : PC_W'(M_LO - 1);
    if (ld_plus) reload = reload + PC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)     pc <= PC_RST;
    else if (tc) pc <= reload;
    else         pc <= pc - PC_W'(1);
  end

endmodule

// File: rtl/ps_swallow_ctl.sv
module ps_swallow_ctl
  import pswallow_pkg::*;
#(
  parameter int RST_N    = 3,
  parameter int RST_A    = 0,
  parameter int RST_MSEL = 0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tc,
  input  ps_cfg_t pend,
  output logic    nx_msel,
  output logic    nx_plus,
  output ps_cfg_t act,
  output logic    div_pulse,
  output logic    mod_ctrl
);

  localparam ps_cfg_t CFG_RST = '{msel: RST_MSEL[0],
                                  n:    PS_N_W'(RST_N),
                                  a:    PS_A_W'(RST_A)};

  logic [PS_N_W-1:0] n_cnt, n_nxt;
  logic [PS_A_W-1:0] a_cnt, a_nxt;
  logic              last;

  // The cycle ends when the final main-count period reaches terminal count.
  assign last = tc && (n_cnt == PS_N_W'(1));

  always_comb begin
    n_nxt   = n_cnt;
    a_nxt   = a_cnt;
    nx_msel = act.msel;
    if (last) begin
      n_nxt   = pend.n;
      a_nxt   = pend.a;
      nx_msel = pend.msel;
    end else if (tc) begin
      n_nxt = n_cnt - PS_N_W'(1);
      if (a_cnt != '0) a_nxt = a_cnt - PS_A_W'(1);
    end
    nx_plus = (a_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_cnt     <= CFG_RST.n;
      a_cnt     <= CFG_RST.a;
      act       <= CFG_RST;
      div_pulse <= 1'b0;
      mod_ctrl  <= (RST_A != 0);
    end else begin
      n_cnt     <= n_nxt;
      a_cnt     <= a_nxt;
      div_pulse <= last;
      if (last) act <= pend;
      if (tc)   mod_ctrl <= nx_plus;
    end
  end

endmodule

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv
  import pswallow_pkg::*;
#(
  parameter int M_LO     = 64,
  parameter int N_MIN    = 3,
  parameter int RST_N    = 3,
  parameter int RST_A    = 0,
  parameter int RST_MSEL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PS_N_W-1:0] n_in,
  input  logic [PS_A_W-1:0] a_in,
  input  logic              msel_in,
  output logic              div_pulse,
  output logic              mod_ctrl,
  output logic              cfg_err
);

  localparam int RST_PLUS = (RST_A != 0) ? 1 : 0;

  ps_cfg_t req;
  ps_cfg_t pend;
  ps_cfg_t act_cfg;
  logic    tc;
  logic    nx_msel;
  logic    nx_plus;

  assign req = '{msel: msel_in, n: n_in, a: a_in};

  ps_cfg_guard #(
    .N_MIN(N_MIN), .RST_N(RST_N), .RST_A(RST_A), .RST_MSEL(RST_MSEL)
  ) u_guard (
    .clk(clk), .rst(rst), .req(req), .pend(pend), .cfg_err(cfg_err)
  );

  ps_dual_mod_prescaler #(
    .M_LO(M_LO), .RST_MSEL(RST_MSEL), .RST_PLUS(RST_PLUS)
  ) u_pre (
    .clk(clk), .rst(rst), .ld_msel(nx_msel), .ld_plus(nx_plus), .tc(tc)
  );

  ps_swallow_ctl #(
    .RST_N(RST_N), .RST_A(RST_A), .RST_MSEL(RST_MSEL)
  ) u_ctl (
    .clk(clk), .rst(rst), .tc(tc), .pend(pend),
    .nx_msel(nx_msel), .nx_plus(nx_plus), .act(act_cfg),
    .div_pulse(div_pulse), .mod_ctrl(mod_ctrl)
  );

endmodule

// File: rtl/ps_fbdiv_checker.sv
module ps_fbdiv_checker
  import pswallow_pkg::*;
#(
  parameter int M_LO  = 64,
  parameter int N_MIN = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [PS_N_W-1:0] n_in,
  input logic [PS_A_W-1:0] a_in,
  input logic              div_pulse,
  input logic              mod_ctrl,
  input logic              cfg_err,
  input ps_cfg_t           act_cfg
);

  int   since_pulse;
  int   want_len;
  logic seen;
  logic in_legal;

  assign in_legal = (int'(n_in) >= N_MIN) && (int'(a_in) < int'(n_in));

  // Length of the cycle that starts at a pulse, taken from the applied setting.
  always_ff @(posedge clk) begin
    if (rst) begin
      since_pulse <= 0;
      want_len    <= 0;
      seen        <= 1'b0;
    end else if (div_pulse) begin
      since_pulse <= 1;
      want_len    <= (act_cfg.msel ? 2 * M_LO : M_LO) * int'(act_cfg.n)
                     + int'(act_cfg.a);
      seen        <= 1'b1;
    end else begin
      since_pulse <= since_pulse + 1;
    end
  end

  a_r1_period_ratio: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && seen) |-> (since_pulse == want_len));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  a_r3_swallow_first: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctrl) |-> div_pulse);

  a_r5_short_n_flag: assert property (@(posedge clk) disable iff (rst)
    (int'(n_in) < N_MIN) |=> cfg_err);

  a_r6_a_not_below_n: assert property (@(posedge clk) disable iff (rst)
    (int'(a_in) >= int'(n_in)) |=> cfg_err);

  a_r7_legal_clears: assert property (@(posedge clk) disable iff (rst)
    in_legal |=> !cfg_err);

  a_r8_reset_outputs: assert property (@(posedge clk)
    rst |=> (!div_pulse && !cfg_err && !mod_ctrl));

endmodule

bind pswallow_fbdiv ps_fbdiv_checker #(.M_LO(M_LO), .N_MIN(N_MIN)) u_chk (
  .clk(clk), .rst(rst), .n_in(n_in), .a_in(a_in),
  .div_pulse(div_pulse), .mod_ctrl(mod_ctrl), .cfg_err(cfg_err),
  .act_cfg(act_cfg)
);

// File: tb/pswallow_fbdiv_bench.sv
module pswallow_fbdiv_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] n_in = '0;
  logic [6:0]  a_in = '0;
  logic        msel_in = 1'b0;
  logic        div_pulse, mod_ctrl, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pswallow_fbdiv u_pswallow_fbdiv (
    .clk(clk), .rst(rst), .n_in(n_in), .a_in(a_in), .msel_in(msel_in),
    .div_pulse(div_pulse), .mod_ctrl(mod_ctrl), .cfg_err(cfg_err)
  );

  // msel, N, A, expected ratio, expected clocks with mod_ctrl high
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{0,  3,  0,  192,    0},
    '{0,  3,  2,  194,  130},
    '{0,  5,  4,  324,  260},
    '{1,  3,  0,  384,    0},
    '{1,  4,  3,  515,  387},
    '{0, 10,  7,  647,  455},
    '{1,  6,  1,  769,  129},
    '{0, 20, 19, 1299, 1235}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int ms, input int n, input int a);
    msel_in = ms[0];
    n_in    = 11'(n);
    a_in    = 7'(a);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  // Called at the negedge of a pulse clock; returns at the next pulse clock.
  task automatic meas(output int len, output int mc);
    len = 1;
    mc  = mod_ctrl ? 1 : 0;
    @(negedge clk);
    chk(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
    while (!div_pulse) begin
      len++;
      mc += mod_ctrl ? 1 : 0;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", 195000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int len, mc, prev;
    // R8: reset state, with an illegal setting held so that defaults must rule
    drive(0, 0, 0);
    repeat (5) @(negedge clk);
    chk(div_pulse == 1'b0, "R8 reset div_pulse", int'(div_pulse), 0);
    chk(mod_ctrl == 1'b0, "R8 reset mod_ctrl", int'(mod_ctrl), 0);
    chk(cfg_err == 1'b0, "R8 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R5 N=0 flagged", int'(cfg_err), 1);
    wait_pulse();
    meas(len, mc);
    chk(len == 192, "R8 default ratio", len, 192);
    prev = 192;

    // R1 R3 R4 R7: vector table, each applied right after a pulse
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][0], VEC[i][1], VEC[i][2]);
      meas(len, mc);
      chk(len == prev, "R4 cycle in progress keeps ratio", len, prev);
      chk(cfg_err == 1'b0, "R7 legal setting clears flag", int'(cfg_err), 0);
      meas(len, mc);
      chk(len == VEC[i][3], "R1 ratio M*N+A", len, VEC[i][3]);
      chk(mc == VEC[i][4], "R3 mod_ctrl clocks A*(M+1)", mc, VEC[i][4]);
      prev = VEC[i][3];
    end

    // R5: N below minimum is rejected and the last setting kept
    drive(1, 2, 0);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R5 N=2 flagged", int'(cfg_err), 1);
    wait_pulse();
    meas(len, mc);
    chk(len == 1299, "R5 setting kept after N=2", len, 1299);

    // R6: A equal to N, then A above N
    drive(0, 5, 5);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R6 A=N flagged", int'(cfg_err), 1);
    drive(1, 4, 9);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R6 A>N flagged", int'(cfg_err), 1);
    wait_pulse();
    meas(len, mc);
    chk(len == 1299, "R6 setting kept after A>=N", len, 1299);

    // R7: legal setting clears the flag and is applied
    drive(0, 7, 3);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R7 flag cleared", int'(cfg_err), 0);
    wait_pulse();
    meas(len, mc);
    chk(len == 451, "R7 new ratio applied", len, 451);
    chk(mc == 195, "R3 mod_ctrl clocks N=7 A=3", mc, 195);

    // R4: change a hundred clocks into a cycle
    len = 1;
    repeat (100) begin
      @(negedge clk);
      len++;
    end
    drive(1, 3, 1);
    @(negedge clk);
    while (!div_pulse) begin
      len++;
      @(negedge clk);
    end
    chk(len == 451, "R4 mid-cycle change not mixed in", len, 451);
    meas(len, mc);
    chk(len == 385, "R4 change applied at boundary", len, 385);

    // R8: reset in the middle of operation restores defaults
    drive(0, 1, 0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0 && mod_ctrl == 1'b0 && cfg_err == 1'b0,
        "R8 mid-run reset outputs", int'({div_pulse, mod_ctrl, cfg_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R5 N=1 flagged", int'(cfg_err), 1);
    wait_pulse();
    meas(len, mc);
    chk(len == 192, "R8 defaults after mid-run reset", len, 192);

    // R9: largest N with largest A
    drive(0, 2047, 127);
    meas(len, mc);
    chk(len == 192, "R4 old ratio before R9 setting", len, 192);
    meas(len, mc);
    chk(len == 131135, "R9 N=2047 A=127 ratio", len, 131135);
    chk(mc == 8255, "R9 mod_ctrl clocks A=127", mc, 8255);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule